// File: doc/BRIEF.md
# DRAM Self-Refresh Entry/Exit Sequencer

This block puts selected SDRAM ranks into self-refresh and brings them back out, on behalf of a user who holds a level request. The request is paired with a per-rank mask: each mask bit stands for one chip select, and a 1 means that rank takes part. For example, with four ranks the mask 4'b0101 parks ranks 0 and 2, while ranks 1 and 3 stay active. Nothing happens until the memory reports that initialization is done. A request raised earlier simply waits, because it is a level.

Entry comes as early as the timing allows. If any bank on a chosen rank is open, a precharge-all goes to those ranks first, and the precharge-to-idle time must pass. Then a self-refresh command is issued, and clock-enable drops on the chosen ranks in the same cycle. Clock-enable must stay low for a minimum residency. Once the request is released and that minimum has passed, clock-enable rises. Only NOP cycles follow for the exit-to-command time, and then the acknowledge falls. The acknowledge rises only after the self-refresh command has gone out. A busy mask tells the main scheduler which ranks it must leave alone from the first command of the sequence to the end of the exit time.

All three timing counts are parameters and must each be at least 1.

Top module: `sr_seq_top`

## Requirements
- R1: In reset and right after it, every `cke` bit is 1, `cmd` is NOP (2'b00), `cmd_cs` is 0, `sr_ack` is 0 and `busy` is 0.
- R2: While `init_done` is 0, no command is issued and `cke` stays all ones. A request held across the rise of `init_done` is served: its first command appears in the cycle after the first clock edge that sees `init_done` high.
- R3: With the sequencer idle, `init_done` high, `sr_req` high, a nonzero `sr_mask` and no open bank on a masked rank, the cycle after that edge carries the self-refresh command (2'b10) with `cmd_cs` equal to the mask and `cke` low on exactly the masked bits.
- R4: If any masked rank has its `bank_open` bit set, a precharge-all (2'b01) with `cmd_cs` equal to the mask is issued first. The self-refresh command follows exactly T_RP cycles later, with NOP in between.
- R5: `cke` of the parked ranks stays low for at least T_CKE cycles, counting the self-refresh cycle. `cke` of ranks that are not parked is never low.
- R6: `sr_ack` rises in the cycle right after the self-refresh command cycle and stays high for the whole residency.
- R7: `cke` rises at the first edge where `sr_req` is low and the minimum residency has passed. Exactly T_XS NOP cycles follow, and `sr_ack` falls at the end of them, T_XS cycles after `cke` rose.
- R8: The mask is captured when the sequence starts. Changes to `sr_mask` after that have no effect on `cke`, `cmd_cs` or `busy` until the exit is complete.
- R9: `busy` equals the captured mask from the first command of a sequence until `sr_ack` falls (or the sequence is abandoned), and is 0 otherwise.
- R10: If `sr_req` drops while the sequencer waits after a precharge-all, no self-refresh command is issued, `sr_ack` stays 0 and the sequencer returns to idle at that edge.
- R11: A request with an all-zero `sr_mask` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done | input | 1 | Memory initialization complete |
| sr_req | input | 1 | Level request to hold ranks in self-refresh |
| sr_mask | input | NUM_CS | Ranks that take part (1 = selected) |
| bank_open | input | NUM_CS | Per-rank flag: some bank is open |
| cmd | output | 2 | Command: 00 NOP, 01 precharge-all, 10 self-refresh entry |
| cmd_cs | output | NUM_CS | Ranks addressed by `cmd` |
| cke | output | NUM_CS | Per-rank clock-enable |
| sr_ack | output | 1 | Ranks are in self-refresh |
| busy | output | NUM_CS | Ranks the scheduler must not address |

## Verification
Every output is registered, so the result of an input seen at clock edge k shows up in the cycle after edge k. The only exceptions are the counted waits: T_RP edges from precharge-all to self-refresh, at least T_CKE edges of residency, and T_XS edges from `cke` rising to `sr_ack` falling. The bench drives inputs at the falling edge. A cycle model in the bench advances on the same rising edge from the same inputs, and every output is compared with it at the next falling edge, so each expected value is checked in the exact cycle it is due. Directed cases cover the init gate, precharge-first entry, an abandoned precharge wait, a zero mask and mask changes during residency. A long stretch of random requests, masks and bank states follows them.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;
    typedef enum logic [1:0] {
        CMD_NOP  = 2'b00,
        CMD_PREA = 2'b01,
        CMD_SRE  = 2'b10
    } sr_cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PRECH,
        PH_RESIDE,
        PH_EXIT
    } sr_phase_e;
endpackage

// File: rtl/sr_timer.sv
module sr_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sr_mask_hold.sv
module sr_mask_hold #(
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [NUM_CS-1:0] mask_in,
    input  logic [NUM_CS-1:0] bank_open,
    output logic [NUM_CS-1:0] held,
    output logic              open_hit
);
    logic [NUM_CS-1:0] held_d, held_q;

    always_comb begin
        held_d = capture ? mask_in : held_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= held_d;
    end

    assign held     = held_q;
    assign open_hit = |(mask_in & bank_open);
endmodule

// File: rtl/sr_seq_top.sv
module sr_seq_top
    import sr_seq_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int T_RP   = 3,
    parameter int T_CKE  = 5,
    parameter int T_XS   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_done,
    input  logic              sr_req,
    input  logic [NUM_CS-1:0] sr_mask,
    input  logic [NUM_CS-1:0] bank_open,
    output logic [1:0]        cmd,
    output logic [NUM_CS-1:0] cmd_cs,
    output logic [NUM_CS-1:0] cke,
    output logic              sr_ack,
    output logic [NUM_CS-1:0] busy
);
    localparam int T_MAX = (T_RP > T_CKE) ? ((T_RP > T_XS) ? T_RP : T_XS)
                                          : ((T_CKE > T_XS) ? T_CKE : T_XS);
    localparam int CNT_W = $clog2(T_MAX + 1);

    typedef struct packed {
        sr_phase_e         ph;
        sr_cmd_e           cmd;
        logic [NUM_CS-1:0] cs;
        logic [NUM_CS-1:0] cke;
        logic              ack;
    } seq_state_t;

    seq_state_t        s_d, s_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_done;
    logic              cap;
    logic [NUM_CS-1:0] held;
    logic              open_hit;

    sr_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sr_mask_hold #(.NUM_CS(NUM_CS)) mask_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (cap),
        .mask_in   (sr_mask),
        .bank_open (bank_open),
        .held      (held),
        .open_hit  (open_hit)
    );

    always_comb begin
        s_d      = s_q;
        s_d.cmd  = CMD_NOP;
        s_d.cs   = '0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap      = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                s_d.cke = '1;
                s_d.ack = 1'b0;
                if (init_done && sr_req && (|sr_mask)) begin
                    cap      = 1'b1;
                    s_d.cs   = sr_mask;
                    tmr_load = 1'b1;
                    if (open_hit) begin
                        s_d.ph  = PH_PRECH;
                        s_d.cmd = CMD_PREA;
                        tmr_val = CNT_W'(T_RP - 1);
                    end else begin
                        s_d.ph  = PH_RESIDE;
                        s_d.cmd = CMD_SRE;
                        s_d.cke = ~sr_mask;
                        tmr_val = CNT_W'(T_CKE - 1);
                    end
                end
            end
            PH_PRECH: begin
                if (!sr_req) begin
                    s_d.ph = PH_IDLE;
                end else if (tmr_done) begin
                    s_d.ph   = PH_RESIDE;
                    s_d.cmd  = CMD_SRE;
                    s_d.cs   = held;
                    s_d.cke  = ~held;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_CKE - 1);
                end
            end
            PH_RESIDE: begin
                s_d.ack = 1'b1;
                if (tmr_done && !sr_req) begin
                    s_d.ph   = PH_EXIT;
                    s_d.cke  = '1;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_XS - 1);
                end
            end
            PH_EXIT: begin
                if (tmr_done) begin
                    s_d.ph  = PH_IDLE;
                    s_d.ack = 1'b0;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph  <= PH_IDLE;
            s_q.cmd <= CMD_NOP;
            s_q.cs  <= '0;
            s_q.cke <= '1;
            s_q.ack <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd    = s_q.cmd;
    assign cmd_cs = s_q.cs;
    assign cke    = s_q.cke;
    assign sr_ack = s_q.ack;
    assign busy   = (s_q.ph == PH_IDLE) ? '0 : held;
endmodule

// File: rtl/sr_seq_chk.sv
module sr_seq_chk
    import sr_seq_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_done,
    input logic [1:0]        cmd,
    input logic [NUM_CS-1:0] cmd_cs,
    input logic [NUM_CS-1:0] cke,
    input logic              sr_ack,
    input logic [NUM_CS-1:0] busy
);
    AST_IDLE_NO_CMD_BEFORE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && !sr_ack && busy == '0) |=> (cmd == CMD_NOP)); // R2
    AST_CS_MATCHES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NOP) ? (cmd_cs == '0) : (cmd_cs != '0 && cmd_cs == busy)); // R3
    AST_CKE_LOW_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        &(cke | busy)); // R5
    AST_ACK_AFTER_SRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_ack) |-> ($past(cmd) == CMD_SRE)); // R6
    AST_ACK_FALL_CKE_UP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_ack) |-> (&cke && cmd == CMD_NOP)); // R7
    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy != '0 && $past(busy) != '0) |-> (busy == $past(busy))); // R8
    AST_ACK_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sr_ack |-> (busy != '0)); // R9
endmodule

bind sr_seq_top sr_seq_chk #(.NUM_CS(NUM_CS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_done (init_done),
    .cmd       (cmd),
    .cmd_cs    (cmd_cs),
    .cke       (cke),
    .sr_ack    (sr_ack),
    .busy      (busy)
);

// File: tb/sr_seq_top_tb.sv
`timescale 1ns/1ps
module sr_seq_top_tb_top;
    localparam int NCS   = 4;
    localparam int P_RP  = 3;
    localparam int P_CKE = 5;
    localparam int P_XS  = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           init_done = 1'b0;
    logic           sr_req = 1'b0;
    logic [NCS-1:0] sr_mask = '0;
    logic [NCS-1:0] bank_open = '0;
    logic [1:0]     cmd;
    logic [NCS-1:0] cmd_cs, cke, busy;
    logic           sr_ack;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sr_seq_top #(.NUM_CS(NCS), .T_RP(P_RP), .T_CKE(P_CKE), .T_XS(P_XS)) dut_i (
        .clk(clk), .rst_n(rst_n), .init_done(init_done), .sr_req(sr_req),
        .sr_mask(sr_mask), .bank_open(bank_open), .cmd(cmd), .cmd_cs(cmd_cs),
        .cke(cke), .sr_ack(sr_ack), .busy(busy)
    );

    // cycle model: phase 0 idle, 1 precharge wait, 2 parked, 3 exit
    int             m_ph = 0;
    int             m_el = 0;
    logic [NCS-1:0] m_mk = '0;
    logic [1:0]     m_cmd = 2'b00;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_el = 0; m_mk = '0; m_cmd = 2'b00;
        end else begin
            m_cmd = 2'b00;
            case (m_ph)
                0: if (init_done && sr_req && (|sr_mask)) begin
                    m_mk = sr_mask;
                    m_el = 0;
                    if (|(bank_open & sr_mask)) begin m_ph = 1; m_cmd = 2'b01; end
                    else begin m_ph = 2; m_cmd = 2'b10; end
                end
                1: begin
                    m_el++;
                    if (!sr_req) m_ph = 0;
                    else if (m_el == P_RP) begin m_ph = 2; m_el = 0; m_cmd = 2'b10; end
                end
                2: begin
                    m_el++;
                    if (m_el >= P_CKE && !sr_req) begin m_ph = 3; m_el = 0; end
                end
                default: begin
                    m_el++;
                    if (m_el == P_XS) m_ph = 0;
                end
            endcase
        end
    end

    function automatic logic [NCS-1:0] exp_cke();
        return (m_ph == 2) ? ~m_mk : '1;
    endfunction
    function automatic logic exp_ack();
        return (m_ph == 2 && m_el >= 1) || (m_ph == 3);
    endfunction
    function automatic logic [NCS-1:0] exp_busy();
        return (m_ph != 0) ? m_mk : '0;
    endfunction
    function automatic logic [NCS-1:0] exp_cs();
        return (m_cmd != 2'b00) ? m_mk : '0;
    endfunction

    task automatic cmp(string tag, string field, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, field, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        cmp(tag, "cmd",    8'(cmd),    8'(m_cmd));
        cmp(tag, "cmd_cs", 8'(cmd_cs), 8'(exp_cs()));
        cmp(tag, "cke",    8'(cke),    8'(exp_cke()));
        cmp(tag, "sr_ack", 8'(sr_ack), 8'(exp_ack()));
        cmp(tag, "busy",   8'(busy),   8'(exp_busy()));
    endtask

    task automatic cyc(string tag, int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            check_all(tag);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        @(negedge clk);
        check_all("R1");
        cyc("R1", 3);
        rst_n = 1'b1;
        cyc("R1", 2);

        // R2: request pending before init_done
        sr_req = 1'b1; sr_mask = 4'b0101;
        cyc("R2", 10);
        init_done = 1'b1;
        cyc("R2", 1);
        // R3 / R6: entry straight to self-refresh, ack next cycle
        cyc("R3", 1);
        cyc("R6", 3);
        // R8: mask changes during residency are ignored
        sr_mask = 4'b1010;
        cyc("R8", 6);
        // R7: release and exit sequence
        sr_req = 1'b0;
        cyc("R7", P_XS + 4);

        // R4: open bank forces precharge-all first
        bank_open = 4'b0001; sr_mask = 4'b0011; sr_req = 1'b1;
        cyc("R4", P_RP + 2);
        // R5: early release, minimum residency honoured
        sr_req = 1'b0;
        cyc("R5", P_CKE + P_XS + 3);

        // R10: release while waiting after precharge-all
        sr_req = 1'b1; sr_mask = 4'b1000; bank_open = 4'b1000;
        cyc("R10", 1);
        sr_req = 1'b0;
        cyc("R10", 6);

        // R11: zero mask ignored
        sr_req = 1'b1; sr_mask = 4'b0000; bank_open = 4'b1111;
        cyc("R11", 10);
        sr_req = 1'b0;
        cyc("R11", 2);

        // R9: random traffic
        void'($urandom(32'h5EED_1234));
        for (int n = 0; n < 6000; n++) begin
            if ($urandom_range(0, 29) == 0) sr_req = ~sr_req;
            sr_mask   = 4'($urandom_range(0, 15));
            bank_open = ($urandom_range(0, 2) == 0) ? 4'($urandom_range(0, 15)) : 4'b0000;
            cyc("R9", 1);
        end
        sr_req = 1'b0;
        cyc("R9", P_CKE + P_XS + 4);

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule